// File: doc/BRIEF.md
# Auto-Reload Up-Counter Timer

A 16-bit up-counting timer with a small memory-mapped register port. The counter steps once per prescaled tick. When it equals the active reload value, the next tick wraps it to zero and raises an update event. The update event refreshes the buffered prescaler and, optionally, the buffered reload value. It also sets a sticky flag that software clears.

Software can force an update through an event register. A control bit decides whether a new reload value acts at once or waits for the next update. Single-shot operation drops the run enable by itself at the update. A debug-halt input can stall counting when a freeze bit in the debug configuration register is set.

The bus port is a plain synchronous one: a write is captured at the rising clock edge when `bus_en` and `bus_we` are high, and read data is combinational from the address. No stream data crosses the edge, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `reload_timer`

Register offsets (byte addresses):

| Offset | Contents |
|--------|----------|
| 0x00 | control |
| 0x04 | status, bit 0 is the update flag |
| 0x08 | event, bit 0 forces an update; reads 0 |
| 0x0C | counter |
| 0x10 | prescaler value |
| 0x14 | reload value, as written |
| 0x18 | debug configuration, bit 0 is the freeze bit |

## Requirements
- R1: After reset every register reads zero. In the control register, bit 0 is run enable, bit 1 is update block, bit 2 is overflow-only flag source, bit 3 is single-shot and bit 7 is reload buffering. All other control bits read zero.
- R2: While run enable is 1, the counter adds one on each prescaled tick. While run enable is 0, the counter holds. A write of 1 to run enable causes the first tick at the following clock edge.
- R3: The prescaler makes one tick every (prescaler value + 1) running clocks. A newly written prescaler value is used only after the next update event.
- R4: A tick taken while the counter equals the active reload value sets the counter to 0, pulses `upd_pulse` in that cycle and sets the flag at that same edge.
- R5: The flag stays set until software writes 0 to status bit 0; writing 1 to it has no effect. A hardware set and a software clear in the same cycle leave the flag at 1.
- R6: With reload buffering at 0, a write to the reload register is the active reload value from the next cycle on.
- R7: With reload buffering at 1, a written reload value becomes active only at the next update event.
- R8: With single-shot at 1, an update event clears run enable, and the counter then rests at 0.
- R9: With update block at 1, no update event occurs. The flag and the shadow values stay unchanged, but the counter still wraps to 0 and a forced update still clears the counter.
- R10: Writing 1 to event bit 0 clears the counter and the prescaler phase and, unless updates are blocked, loads both shadows. It sets the flag only if the overflow-only source bit is 0. An overflow sets the flag whatever the source bit.
- R11: While `dbg_halt` is 1 and the freeze bit is 1, counter and prescaler hold. With the freeze bit at 0, `dbg_halt` has no effect.
- R12: A write is accepted only with byte strobes 4'b0011, 4'b1100 or 4'b1111; 4'b1100 touches only reserved upper bits. Any other pattern, including every single-byte strobe, leaves all registers unchanged. Reads return the full word whatever the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access select |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wstrb | input | 4 | Byte strobes of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| dbg_halt | input | 1 | Processor halted in debug |
| upd_pulse | output | 1 | High in the cycle whose edge performs an update event |
| upd_flag | output | 1 | Sticky update flag |

## Verification
Two functions can meet in one cycle: the hardware setting of the flag on overflow, and a software write that clears it. The bench lets the counter run with a small reload value. It issues the clear write in exactly the cycle where the counter equals the reload value, so that both act at the same edge. The flag must read 1 afterwards. A clear issued one cycle later must read 0, which shows that the clear path itself works.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_EVGEN  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PRESC  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DBG    = 5'h18;

  // control fields, packed from bit 7 down to bit 0 of the register
  typedef struct packed {
    logic buf_reload;  // bit 7
    logic one_shot;    // bit 3
    logic ovf_only;    // bit 2
    logic upd_block;   // bit 1
    logic run_en;      // bit 0
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    return {{(DATA_W-8){1'b0}}, c.buf_reload, 3'b000,
            c.one_shot, c.ovf_only, c.upd_block, c.run_en};
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.buf_reload = w[7];
    c.one_shot   = w[3];
    c.ovf_only   = w[2];
    c.upd_block  = w[1];
    c.run_en     = w[0];
    return c;
  endfunction

  // half-word or word strobes only
  function automatic logic strobe_legal(input logic [STRB_W-1:0] s);
    return (s == 4'b0011) || (s == 4'b1100) || (s == 4'b1111);
  endfunction
endpackage

// File: rtl/rtmr_regs.sv
module rtmr_regs
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STRB_W-1:0] bus_wstrb,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              uev,
  input  logic              flag_set,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  psc_pre,
  output logic [CNT_W-1:0]  arr_pre,
  output logic              freeze,
  output logic              flag,
  output logic              sw_gen,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic wr_any, wr_legal, wr_low, wr_narrow;
  logic hit_ctrl, hit_stat, hit_evgen, hit_count, hit_presc, hit_reload, hit_dbg;
  logic flag_clr;
  logic unused_hi;

  assign wr_any    = bus_en && bus_we;
  assign wr_legal  = wr_any && strobe_legal(bus_wstrb);
  assign wr_low    = wr_legal && bus_wstrb[0];
  assign wr_narrow = wr_any && !strobe_legal(bus_wstrb);
  assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

  assign hit_ctrl   = (bus_addr == OFS_CTRL);
  assign hit_stat   = (bus_addr == OFS_STAT);
  assign hit_evgen  = (bus_addr == OFS_EVGEN);
  assign hit_count  = (bus_addr == OFS_COUNT);
  assign hit_presc  = (bus_addr == OFS_PRESC);
  assign hit_reload = (bus_addr == OFS_RELOAD);
  assign hit_dbg    = (bus_addr == OFS_DBG);

  assign flag_clr  = wr_low && hit_stat && !bus_wdata[0];
  assign sw_gen    = wr_low && hit_evgen && bus_wdata[0];
  assign cnt_wr    = wr_low && hit_count;
  assign cnt_wdata = bus_wdata[CNT_W-1:0];

  // control: bus write first, single-shot clear of run enable overrides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_low && hit_ctrl) ctrl <= word_to_ctrl(bus_wdata);
      if (uev && ctrl.one_shot) ctrl.run_en <= 1'b0;
    end
  end

  // sticky flag: hardware set wins over software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else begin
      if (flag_clr) flag <= 1'b0;
      if (flag_set) flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_pre <= '0;
      arr_pre <= '0;
      freeze  <= 1'b0;
    end else begin
      if (wr_low && hit_presc)  psc_pre <= bus_wdata[CNT_W-1:0];
      if (wr_low && hit_reload) arr_pre <= bus_wdata[CNT_W-1:0];
      if (wr_low && hit_dbg)    freeze  <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (1'b1)
        hit_ctrl:   bus_rdata = ctrl_to_word(ctrl);
        hit_stat:   bus_rdata = {{(DATA_W-1){1'b0}}, flag};
        hit_count:  bus_rdata = {{PAD_W{1'b0}}, cnt_val};
        hit_presc:  bus_rdata = {{PAD_W{1'b0}}, psc_pre};
        hit_reload: bus_rdata = {{PAD_W{1'b0}}, arr_pre};
        hit_dbg:    bus_rdata = {{(DATA_W-1){1'b0}}, freeze};
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag); // R5
  AST_SINGLE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    uev && ctrl.one_shot |=> !ctrl.run_en); // R8
  AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_narrow && !uev |=> $stable(ctrl) && $stable(psc_pre)
                         && $stable(arr_pre) && $stable(freeze)); // R12
endmodule

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sw_gen,
  input  logic             uev,
  input  logic [CNT_W-1:0] psc_pre,
  output logic             tick
);
  logic [CNT_W-1:0] psc_sh;
  logic [CNT_W-1:0] phase;
  logic             at_end;

  assign at_end = (phase == psc_sh);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (sw_gen) begin
      phase <= '0;
    end else if (run) begin
      phase <= at_end ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   psc_sh <= '0;
    else if (uev) psc_sh <= psc_pre;
  end

  AST_PSC_WAITS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(psc_sh)); // R3
  AST_PHASE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !sw_gen |=> $stable(phase)); // R11
endmodule

// File: rtl/rtmr_count.sv
module rtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_gen,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] arr_pre,
  input  logic             buf_reload,
  input  logic             upd_block,
  input  logic             ovf_only,
  output logic [CNT_W-1:0] cnt,
  output logic             uev,
  output logic             flag_set
);
  logic [CNT_W-1:0] arr_sh;
  logic [CNT_W-1:0] arr_act;
  logic             ovf;

  assign arr_act  = buf_reload ? arr_sh : arr_pre;
  assign ovf      = tick && (cnt == arr_act);
  assign uev      = !upd_block && (ovf || sw_gen);
  assign flag_set = uev && (ovf || !ovf_only);

  // force > software load > tick
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (sw_gen)  cnt <= '0;
    else if (cnt_wr)  cnt <= cnt_wdata;
    else if (tick)    cnt <= ovf ? '0 : cnt + 1'b1;
  end

  // shadow tracks the written value while unbuffered
  always_ff @(posedge clk) begin
    if (!rst_n)                  arr_sh <= '0;
    else if (!buf_reload || uev) arr_sh <= arr_pre;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !sw_gen && !cnt_wr |=> cnt == '0); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !sw_gen && !cnt_wr |=> $stable(cnt)); // R2
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_reload && !uev |=> $stable(arr_sh)); // R7
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [STRB_W-1:0] bus_wstrb,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              upd_pulse,
  output logic              upd_flag
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] psc_pre, arr_pre, cnt, cnt_wdata;
  logic             freeze, sw_gen, cnt_wr, uev, flag_set, tick, run;

  assign run       = ctrl.run_en && !(dbg_halt && freeze);
  assign upd_pulse = uev;

  rtmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt), .uev(uev), .flag_set(flag_set),
    .ctrl(ctrl), .psc_pre(psc_pre), .arr_pre(arr_pre), .freeze(freeze),
    .flag(upd_flag), .sw_gen(sw_gen), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata)
  );

  rtmr_prescale #(.CNT_W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .sw_gen(sw_gen),
    .uev(uev), .psc_pre(psc_pre), .tick(tick)
  );

  rtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_gen(sw_gen),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .arr_pre(arr_pre),
    .buf_reload(ctrl.buf_reload), .upd_block(ctrl.upd_block),
    .ovf_only(ctrl.ovf_only), .cnt(cnt), .uev(uev), .flag_set(flag_set)
  );

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt && freeze && !sw_gen && !cnt_wr |=> $stable(cnt)); // R11
  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run_en |-> !tick); // R2
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        upd_pulse, upd_flag;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_EVG = 5'h08,
                         A_CNT = 5'h0C, A_PSC = 5'h10, A_RLD = 5'h14, A_DBG = 5'h18;

  always #2 clk = ~clk;

  reload_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .upd_pulse(upd_pulse), .upd_flag(upd_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s = 4'b1111);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, input logic [3:0] s = 4'b0001);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wstrb = s;
    #0.5;
    d = bus_rdata;
    bus_en = 1'b0; bus_wstrb = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; dbg_halt = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_reset();
    rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    rd(A_CNT, v);  check("R1 count reset", v, 0);
    rd(A_PSC, v);  check("R1 prescaler reset", v, 0);
    rd(A_RLD, v);  check("R1 reload reset", v, 0);
    rd(A_DBG, v);  check("R1 debug cfg reset", v, 0);
    check("R1 flag reset", upd_flag, 0);
    wr(A_CTRL, 32'hFFFE);
    rd(A_CTRL, v); check("R1 ctrl bit map", v, 32'h8E);
  endtask

  task automatic t_count;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 100);
    wr(A_CTRL, 32'h1);
    wait_n(5);
    rd(A_CNT, v); check("R2 counts one per clock", v, 5);
    wr(A_CTRL, 32'h0);
    wait_n(5);
    rd(A_CNT, v); check("R2 holds when disabled", v, 6);
  endtask

  task automatic t_wrap_and_flag;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 3);
    wr(A_CTRL, 32'h1);
    wait_n(3);
    rd(A_CNT, v); check("R4 at reload value", v, 3);
    check("R4 update pulse before wrap", upd_pulse, 1);
    check("R4 flag not yet set", upd_flag, 0);
    wait_n(1);
    rd(A_CNT, v); check("R4 wrapped to zero", v, 0);
    check("R4 flag set on wrap", upd_flag, 1);
    wr(A_STAT, 32'h1);
    check("R5 writing one keeps flag", upd_flag, 1);
    wr(A_STAT, 32'h0);
    check("R5 writing zero clears flag", upd_flag, 0);
    // count now 2: one edge to reach 3, then clear coincides with wrap
    wait_n(1);
    rd(A_CNT, v); check("R5 aligned on reload value", v, 3);
    wr(A_STAT, 32'h0);
    check("R5 set beats same-cycle clear", upd_flag, 1);
    wr(A_STAT, 32'h0);
    check("R5 later clear works", upd_flag, 0);
  endtask

  task automatic t_prescale_and_force;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 100);
    wr(A_PSC, 2);
    wr(A_CTRL, 32'h1);
    wait_n(3);
    rd(A_CNT, v); check("R3 new prescaler not yet used", v, 3);
    wr(A_EVG, 32'h1);
    rd(A_CNT, v); check("R10 forced update clears counter", v, 0);
    check("R10 forced update sets flag", upd_flag, 1);
    wait_n(2);
    rd(A_CNT, v); check("R3 no tick before divide", v, 0);
    wait_n(1);
    rd(A_CNT, v); check("R3 first divided tick", v, 1);
    wait_n(3);
    rd(A_CNT, v); check("R3 divide by three", v, 2);
  endtask

  task automatic t_preload;
    logic [31:0] v;
    do_reset();
    wr(A_CTRL, 32'h80);
    wr(A_RLD, 5);
    wr(A_EVG, 32'h1);
    wr(A_STAT, 32'h0);
    wr(A_CTRL, 32'h81);
    wr(A_RLD, 2);
    wait_n(2);
    rd(A_CNT, v); check("R7 buffered value not active", v, 3);
    wait_n(3);
    rd(A_CNT, v); check("R7 old value used for wrap", v, 0);
    check("R7 flag at old wrap", upd_flag, 1);
    wr(A_STAT, 32'h0);
    wait_n(2);
    rd(A_CNT, v); check("R7 new value active after update", v, 0);
    check("R7 flag at new wrap", upd_flag, 1);
  endtask

  task automatic t_immediate;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 10);
    wr(A_CTRL, 32'h1);
    wait_n(4);
    wr(A_RLD, 6);
    wait_n(1);
    rd(A_CNT, v); check("R6 reaches new value", v, 6);
    wait_n(1);
    rd(A_CNT, v); check("R6 wraps at new value", v, 0);
    check("R6 flag at new value", upd_flag, 1);
  endtask

  task automatic t_single_shot;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 2);
    wr(A_CTRL, 32'h9);
    wait_n(6);
    rd(A_CNT, v);  check("R8 rests at zero", v, 0);
    rd(A_CTRL, v); check("R8 run enable cleared", v, 32'h8);
    check("R8 flag set", upd_flag, 1);
  endtask

  task automatic t_block;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 2);
    wr(A_PSC, 3);
    wr(A_CTRL, 32'h3);
    wait_n(3);
    rd(A_CNT, v); check("R9 still wraps", v, 0);
    check("R9 no flag", upd_flag, 0);
    wait_n(2);
    rd(A_CNT, v); check("R9 prescaler shadow unchanged", v, 2);
    wr(A_EVG, 32'h1);
    rd(A_CNT, v); check("R9 forced clear still acts", v, 0);
    check("R9 forced update gives no flag", upd_flag, 0);
  endtask

  task automatic t_source;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 1);
    wr(A_CTRL, 32'h4);
    wr(A_EVG, 32'h1);
    check("R10 overflow-only hides forced flag", upd_flag, 0);
    wr(A_CTRL, 32'h5);
    wait_n(2);
    rd(A_CNT, v); check("R10 wrap with overflow-only", v, 0);
    check("R10 overflow still flags", upd_flag, 1);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    do_reset();
    wr(A_DBG, 32'h1);
    wr(A_RLD, 100);
    wr(A_CTRL, 32'h1);
    wait_n(3);
    dbg_halt = 1'b1;
    wait_n(4);
    rd(A_CNT, v); check("R11 frozen while halted", v, 3);
    wr(A_DBG, 32'h0);
    wait_n(2);
    rd(A_CNT, v); check("R11 halt ignored without freeze", v, 5);
    dbg_halt = 1'b0;
  endtask

  task automatic t_width;
    logic [31:0] v;
    do_reset();
    wr(A_RLD, 32'h1234, 4'b0001);
    wr(A_RLD, 32'h1234, 4'b0010);
    wr(A_RLD, 32'h1234, 4'b0111);
    rd(A_RLD, v); check("R12 narrow writes ignored", v, 0);
    wr(A_RLD, 32'h1234, 4'b1100);
    rd(A_RLD, v); check("R12 upper half touches reserved only", v, 0);
    wr(A_CTRL, 32'h1, 4'b0001);
    wait_n(3);
    rd(A_CNT, v); check("R12 byte write left timer stopped", v, 0);
    wr(A_RLD, 32'h1234, 4'b1111);
    rd(A_RLD, v, 4'b1111); check("R12 word write accepted", v, 32'h1234);
    wr(A_RLD, 32'h0055, 4'b0011);
    rd(A_RLD, v, 4'b0010); check("R12 half-word write, byte read", v, 32'h55);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap_and_flag();
    t_prescale_and_force();
    t_preload();
    t_immediate();
    t_single_shot();
    t_block();
    t_source();
    t_freeze();
    t_width();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule